// File: doc/BRIEF.md
# Audio DMA Channel Control Register

This block holds the single 32-bit control word of a memory-to-stream audio DMA channel. It sits between a simple register write/read port and the channel's datapath. From the stored fields it drives the channel count, the sample width code, the run request and the two interrupt enables to the datapath. It takes back a busy indication for in-flight work, a period-done pulse and an error pulse.

The block does not stop or reset the channel abruptly. Clearing the run bit moves the channel into a draining phase. It is reported as halted only after the datapath has gone idle. Writing the soft-reset bit starts a reset phase that also waits for the datapath to go idle. During that phase the stream output is told to cut short, and at the end every field returns to its default.

The controller has four states. ST_HALT is idle with the halted flag set. ST_RUN is active. ST_DRAIN means run has been cleared and in-flight work is finishing. ST_SRST means a soft reset is in progress. The transitions are:
- HALT→RUN when the run bit is set.
- RUN→DRAIN when the run bit is cleared.
- DRAIN→HALT when busy is low.
- Any state except SRST goes to SRST on a write of 1 to the soft-reset bit.
- SRST→HALT when busy is low. On this transition all fields go back to their defaults.

Interrupts are a level output. It is the OR of two sticky flags, one for completion and one for error, each gated by its enable. Each flag is cleared by its own acknowledge pulse.

Top module: `dma_ctrl_reg`

## Requirements
- R1: After reset the control word reads 0x00122000: 2 channels, width code 2, completion enable 1, error enable 0, soft reset 0, run 0. The halted flag is 1 and irq is 0.
- R2: The word layout is as follows. Bits 22:19 hold the channel count. Bits 18:16 hold the width code (0=8, 1=16, 2=20, 3=24, 4=32 bits). Bit 13 is the completion-interrupt enable and bit 12 is the error-interrupt enable. Bit 1 is soft reset and bit 0 is run. All other bits read 0 whatever is written.
- R3: A write whose channel count is not 2, 4, 6 or 8, or exceeds the MAX_CH parameter, leaves the channel field unchanged. The other fields of that write still take effect.
- R4: A write whose width code is above 4 leaves the width field unchanged.
- R5: Writing run=1 while halted drives ctl_run high after that write's clock edge. The halted flag clears one cycle later.
- R6: After run is cleared, halted stays 0 while dp_busy is 1. It becomes 1 on the first clock edge that sees dp_busy low in the draining state.
- R7: A write with bit 1 set starts a soft reset. While dp_busy stays high, bit 1 reads 1, ctl_srst is 1, ctl_run is 0, and further writes are ignored.
- R8: A soft reset ends on the first clock edge with dp_busy low. After it, the word reads 0x00122000, both interrupt flags are clear and halted is 1.
- R9: A dp_period_done pulse sets a sticky completion flag. irq follows it one cycle later when the completion enable is 1. An ack_done pulse clears the flag.
- R10: A dp_error pulse sets a sticky error flag. irq follows it when the error enable is 1. An ack_err pulse clears the flag.
- R11: A flag set while its enable is 0 does not raise irq. It raises irq as soon as the enable is written to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control word |
| dp_busy | input | 1 | Datapath has in-flight work |
| dp_period_done | input | 1 | Pulse: one period transferred |
| dp_error | input | 1 | Pulse: datapath error |
| ack_done | input | 1 | Pulse: clear completion flag |
| ack_err | input | 1 | Pulse: clear error flag |
| ctl_run | output | 1 | Run request to datapath |
| ctl_srst | output | 1 | Soft reset in progress; stream is to be cut short |
| ctl_chans | output | 4 | Channel count |
| ctl_width | output | 3 | Sample width code |
| ctl_ien_done | output | 1 | Completion-interrupt enable |
| ctl_ien_err | output | 1 | Error-interrupt enable |
| halted | output | 1 | Channel is halted |
| irq | output | 1 | Interrupt level |

## Verification
The hardest situation to reach is a soft reset issued while the channel is running with work in flight and a pending interrupt. The reset must hold, ignore writes and then restore every default. The stimulus gets there by loading non-default fields with run set and dp_busy held high, and by raising the completion flag first. It then writes the reset bit and a second, ignored word, and checks the readback before and after dropping dp_busy. The drain path is reached the same way, with dp_busy held across the run-clear write.

// File: rtl/dma_ctrl_pkg.sv
package dma_ctrl_pkg;

    localparam int CH_W  = 4;
    localparam int WID_W = 3;

    localparam int POS_RUN  = 0;
    localparam int POS_SRST = 1;
    localparam int POS_IERR = 12;
    localparam int POS_IDON = 13;
    localparam int POS_WID  = 16;
    localparam int POS_CH   = 19;

    localparam logic [CH_W-1:0]  DEF_CHANS = CH_W'(2);
    localparam logic [WID_W-1:0] DEF_WIDTH = WID_W'(2);
    localparam logic             DEF_IDON  = 1'b1;
    localparam logic             DEF_IERR  = 1'b0;
    localparam logic [WID_W-1:0] MAX_WCODE = WID_W'(4);

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_SRST  = 2'd3
    } chan_state_t;

    function automatic logic chans_ok(input logic [CH_W-1:0] v, input int max_ch);
        return (v != '0) && !v[0] && (int'(v) <= 8) && (int'(v) <= max_ch);
    endfunction

endpackage

// File: rtl/dma_ctrl_fsm.sv
module dma_ctrl_fsm
    import dma_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run_q,
    input  logic        srst_wr,
    input  logic        dp_busy,
    output chan_state_t state,
    output logic        halted,
    output logic        srst_active,
    output logic        srst_done
);

    chan_state_t state_nx;

    always_comb begin
        state_nx = state;
        if (srst_wr) begin
            state_nx = ST_SRST;
        end else begin
            unique case (state)
                ST_HALT:  if (run_q)    state_nx = ST_RUN;
                ST_RUN:   if (!run_q)   state_nx = ST_DRAIN;
                ST_DRAIN: if (!dp_busy) state_nx = ST_HALT;
                ST_SRST:  if (!dp_busy) state_nx = ST_HALT;
                default:                state_nx = ST_HALT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_nx;
    end

    always_comb begin
        halted      = (state == ST_HALT);
        srst_active = (state == ST_SRST);
        srst_done   = (state == ST_SRST) && !dp_busy;
    end

endmodule

// File: rtl/dma_ctrl_fields.sv
module dma_ctrl_fields
    import dma_ctrl_pkg::*;
#(
    parameter int MAX_CH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CH_W-1:0]  w_chans,
    input  logic [WID_W-1:0] w_width,
    input  logic             w_idon,
    input  logic             w_ierr,
    input  logic             w_srst,
    input  logic             w_run,
    input  logic             srst_active,
    input  logic             srst_done,
    output logic [CH_W-1:0]  chans,
    output logic [WID_W-1:0] width,
    output logic             ien_done,
    output logic             ien_err,
    output logic             run_q
);

    logic take;
    assign take = wr && !srst_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chans    <= DEF_CHANS;
            width    <= DEF_WIDTH;
            ien_done <= DEF_IDON;
            ien_err  <= DEF_IERR;
            run_q    <= 1'b0;
        end else if (srst_done) begin
            chans    <= DEF_CHANS;
            width    <= DEF_WIDTH;
            ien_done <= DEF_IDON;
            ien_err  <= DEF_IERR;
            run_q    <= 1'b0;
        end else if (take && w_srst) begin
            run_q <= 1'b0;
        end else if (take) begin
            if (chans_ok(w_chans, MAX_CH)) chans <= w_chans;
            if (w_width <= MAX_WCODE)      width <= w_width;
            ien_done <= w_idon;
            ien_err  <= w_ierr;
            run_q    <= w_run;
        end
    end

endmodule

// File: rtl/dma_ctrl_irq.sv
module dma_ctrl_irq #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_all,
    input  logic [NSRC-1:0] set,
    input  logic [NSRC-1:0] ack,
    input  logic [NSRC-1:0] en,
    output logic            irq
);

    logic [NSRC-1:0] flag;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flag[i] <= 1'b0;
            else if (clr_all) flag[i] <= 1'b0;
            else if (set[i])  flag[i] <= 1'b1;
            else if (ack[i])  flag[i] <= 1'b0;
        end
    end

    assign irq = |(flag & en);

endmodule

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
    import dma_ctrl_pkg::*;
#(
    parameter int MAX_CH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        dp_busy,
    input  logic        dp_period_done,
    input  logic        dp_error,
    input  logic        ack_done,
    input  logic        ack_err,
    output logic        ctl_run,
    output logic        ctl_srst,
    output logic [3:0]  ctl_chans,
    output logic [2:0]  ctl_width,
    output logic        ctl_ien_done,
    output logic        ctl_ien_err,
    output logic        halted,
    output logic        irq
);

    chan_state_t state;
    logic        run_q, srst_active, srst_done, srst_wr;
    logic        unused_wbits;

    assign srst_wr      = reg_wr && reg_wdata[POS_SRST] && (state != ST_SRST);
    assign unused_wbits = ^{reg_wdata[31:23], reg_wdata[15:14], reg_wdata[11:2]};

    dma_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_q       (run_q),
        .srst_wr     (srst_wr),
        .dp_busy     (dp_busy),
        .state       (state),
        .halted      (halted),
        .srst_active (srst_active),
        .srst_done   (srst_done)
    );

    dma_ctrl_fields #(.MAX_CH(MAX_CH)) u_fields (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (reg_wr),
        .w_chans     (reg_wdata[POS_CH +: CH_W]),
        .w_width     (reg_wdata[POS_WID +: WID_W]),
        .w_idon      (reg_wdata[POS_IDON]),
        .w_ierr      (reg_wdata[POS_IERR]),
        .w_srst      (reg_wdata[POS_SRST]),
        .w_run       (reg_wdata[POS_RUN]),
        .srst_active (srst_active),
        .srst_done   (srst_done),
        .chans       (ctl_chans),
        .width       (ctl_width),
        .ien_done    (ctl_ien_done),
        .ien_err     (ctl_ien_err),
        .run_q       (run_q)
    );

    dma_ctrl_irq #(.NSRC(2)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (srst_done),
        .set     ({dp_error, dp_period_done}),
        .ack     ({ack_err, ack_done}),
        .en      ({ctl_ien_err, ctl_ien_done}),
        .irq     (irq)
    );

    assign ctl_run  = run_q && !srst_active;
    assign ctl_srst = srst_active;

    always_comb begin
        reg_rdata                     = '0;
        reg_rdata[POS_CH +: CH_W]     = ctl_chans;
        reg_rdata[POS_WID +: WID_W]   = ctl_width;
        reg_rdata[POS_IDON]           = ctl_ien_done;
        reg_rdata[POS_IERR]           = ctl_ien_err;
        reg_rdata[POS_SRST]           = srst_active;
        reg_rdata[POS_RUN]            = run_q;
    end

endmodule

// File: rtl/dma_ctrl_reg_chk.sv
module dma_ctrl_reg_chk #(
    parameter int MAX_CH = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] reg_rdata,
    input logic        dp_busy,
    input logic        ctl_run,
    input logic        ctl_srst,
    input logic [3:0]  ctl_chans,
    input logic [2:0]  ctl_width,
    input logic        halted
);

    localparam logic [31:0] RSV_MASK = 32'hFF80_CFFC;

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & RSV_MASK) == 32'h0);

    assert_chans_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_chans != 4'd0) && !ctl_chans[0] && (int'(ctl_chans) <= 8) && (int'(ctl_chans) <= MAX_CH));

    assert_width_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_width <= 3'd4);

    assert_halt_after_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> !$past(dp_busy));

    assert_no_run_in_srst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_run && ctl_srst));

    assert_srst_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_srst && dp_busy) |=> ctl_srst);

    assert_srst_defaults_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_srst) |-> (ctl_chans == 4'd2 && ctl_width == 3'd2 && halted));

endmodule

bind dma_ctrl_reg dma_ctrl_reg_chk #(.MAX_CH(MAX_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rdata (reg_rdata),
    .dp_busy   (dp_busy),
    .ctl_run   (ctl_run),
    .ctl_srst  (ctl_srst),
    .ctl_chans (ctl_chans),
    .ctl_width (ctl_width),
    .halted    (halted)
);

// File: tb/dma_ctrl_reg_tb.sv
module dma_ctrl_reg_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dp_busy = 1'b0, dp_period_done = 1'b0, dp_error = 1'b0;
    logic        ack_done = 1'b0, ack_err = 1'b0;
    logic        ctl_run, ctl_srst, ctl_ien_done, ctl_ien_err, halted, irq;
    logic [3:0]  ctl_chans;
    logic [2:0]  ctl_width;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dma_ctrl_reg #(.MAX_CH(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dp_busy(dp_busy), .dp_period_done(dp_period_done),
        .dp_error(dp_error), .ack_done(ack_done), .ack_err(ack_err),
        .ctl_run(ctl_run), .ctl_srst(ctl_srst), .ctl_chans(ctl_chans),
        .ctl_width(ctl_width), .ctl_ien_done(ctl_ien_done), .ctl_ien_err(ctl_ien_err),
        .halted(halted), .irq(irq)
    );

    // {write word, expected readback}
    localparam logic [63:0] VEC [6] = '{
        {32'h0024_3000, 32'h0024_3000},   // R2 legal fields
        {32'h0019_2000, 32'h0021_2000},   // R3 odd channel count kept, width taken
        {32'hFFC5_DFFC, 32'h0041_1000},   // R4 width 5 kept, reserved read 0 (R2)
        {32'h0000_0000, 32'h0040_0000},   // R3 zero channels kept
        {32'h0053_2000, 32'h0043_2000},   // R3 count 10 above max kept
        {32'h0030_2000, 32'h0030_2000}    // R2 six channels, width 0
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); dp_period_done = 1'b1; @(negedge clk); dp_period_done = 1'b0;
    endtask
    task automatic pulse_err();
        @(negedge clk); dp_error = 1'b1; @(negedge clk); dp_error = 1'b0;
    endtask
    task automatic pulse_ack_done();
        @(negedge clk); ack_done = 1'b1; @(negedge clk); ack_done = 1'b0;
    endtask
    task automatic pulse_ack_err();
        @(negedge clk); ack_err = 1'b1; @(negedge clk); ack_err = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rdata", reg_rdata, 32'h0012_2000);
        check("R1 halted", {31'b0, halted}, 32'd1);
        check("R1 irq", {31'b0, irq}, 32'd0);
        check("R1 ctl_run", {31'b0, ctl_run}, 32'd0);

        // Table walk: R2 R3 R4
        for (int i = 0; i < 6; i++) begin
            wr(VEC[i][63:32]);
            check($sformatf("R2/R3/R4 vec%0d", i), reg_rdata, VEC[i][31:0]);
        end
        check("R3 ctl_chans", {28'b0, ctl_chans}, 32'd6);
        check("R4 ctl_width", {29'b0, ctl_width}, 32'd0);

        // R5 run start
        wr(32'h0012_2001);
        check("R5 ctl_run", {31'b0, ctl_run}, 32'd1);
        check("R5 halted still set", {31'b0, halted}, 32'd1);
        @(negedge clk);
        check("R5 halted cleared", {31'b0, halted}, 32'd0);

        // R6 graceful stop
        dp_busy = 1'b1;
        wr(32'h0012_2000);
        check("R6 ctl_run low", {31'b0, ctl_run}, 32'd0);
        repeat (4) @(negedge clk);
        check("R6 halted held while busy", {31'b0, halted}, 32'd0);
        dp_busy = 1'b0;
        @(negedge clk);
        check("R6 halted after idle", {31'b0, halted}, 32'd1);

        // R9 completion interrupt
        pulse_done();
        check("R9 irq set", {31'b0, irq}, 32'd1);
        repeat (3) @(negedge clk);
        check("R9 irq sticky", {31'b0, irq}, 32'd1);
        pulse_ack_done();
        check("R9 irq cleared", {31'b0, irq}, 32'd0);

        // R11 error flag while error enable is 0
        pulse_err();
        check("R11 irq gated", {31'b0, irq}, 32'd0);
        wr(32'h0012_1000);
        check("R11 irq after enable", {31'b0, irq}, 32'd1);
        // R10 ack clears error flag
        pulse_ack_err();
        check("R10 irq cleared", {31'b0, irq}, 32'd0);
        pulse_err();
        check("R10 irq set", {31'b0, irq}, 32'd1);
        pulse_ack_err();
        check("R10 irq cleared again", {31'b0, irq}, 32'd0);
        // R11 completion flag while disabled
        pulse_done();
        check("R11 done gated", {31'b0, irq}, 32'd0);
        wr(32'h0012_2000);
        check("R11 done after enable", {31'b0, irq}, 32'd1);

        // R7 / R8 soft reset under load, completion flag pending
        dp_busy = 1'b1;
        wr(32'h0024_3001);
        @(negedge clk);
        check("R7 running", {31'b0, ctl_run}, 32'd1);
        wr(32'h0000_0002);
        check("R7 srst reads 1", reg_rdata, 32'h0024_3002);
        check("R7 ctl_srst", {31'b0, ctl_srst}, 32'd1);
        check("R7 ctl_run low", {31'b0, ctl_run}, 32'd0);
        wr(32'h0030_2001);
        repeat (3) @(negedge clk);
        check("R7 write ignored", reg_rdata, 32'h0024_3002);
        check("R7 still in reset", {31'b0, ctl_srst}, 32'd1);
        dp_busy = 1'b0;
        @(negedge clk);
        check("R8 defaults", reg_rdata, 32'h0012_2000);
        check("R8 halted", {31'b0, halted}, 32'd1);
        check("R8 irq cleared", {31'b0, irq}, 32'd0);
        check("R8 ctl_srst low", {31'b0, ctl_srst}, 32'd0);

        // R8 soft reset with idle datapath ends after one cycle
        wr(32'h0030_2000);
        wr(32'h0000_0002);
        check("R8 one-cycle reset", {31'b0, ctl_srst}, 32'd1);
        @(negedge clk);
        check("R8 idle reset done", reg_rdata, 32'h0012_2000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule